// File: doc/BRIEF.md
# GPIO Port with Peripheral Override Controls

This block controls a port of general-purpose pins whose width is set by a parameter. For each pin it keeps a direction bit and an output-value bit, loaded through two write strobes that share one data bus. Both bits can be read back. From these bits it drives four pad controls: pull-up enable, output enable, output value and input enable.

A peripheral sharing the pins can take over any pad control. Each control has its own enable and value pair, given per pin. When the enable bit is 1, the value bit decides the control; when it is 0, the port registers decide it. A further per-pin toggle input inverts the stored output bit.

The pad input is gated by the input enable. The gated input then takes two paths. One path runs through a two-flop synchronizer into the readable pin value. The other goes to peripherals directly, with no synchronizer, so each peripheral can apply its own synchronization.

Top module: `gpio_override_port`

## Requirements
- R1: With the pull-up override enable at 0, a pin's pull-up is 1 only when its direction bit is 0, its output bit is 1 and the global pull-up disable is 0. Every other combination gives 0.
- R2: With the pull-up override enable at 1, the pull-up equals the pull-up override value, whatever the direction, output and global disable bits are.
- R3: With the direction override enable at 0, the output enable equals the direction bit (1 = drive). With it at 1, the output enable equals the direction override value.
- R4: When the output enable is 1 and the value override enable is 1, the pad output equals the value override value. In every other case the pad output equals the stored output bit.
- R5: In each clock cycle with no output write, a 1 on a pin's toggle input inverts that pin's stored output bit once. A toggle held for N cycles inverts the bit N times.
- R6: An output write in the same cycle as a toggle loads the written data, and the toggle is lost.
- R7: With the input-enable override enable at 0, the input enable is 1 when the sleep input is 0 and 0 when the sleep input is 1. With the override enable at 1, the input enable equals the override value, whatever the sleep input is.
- R8: When a pin's input enable is 0, both the raw peripheral input and the synchronized pin value for that pin read 0, whatever the pad level is.
- R9: The raw peripheral input follows the gated pad input in the same cycle, with no register on the path.
- R10: A change of the gated pad input made between clock edges shows in the pin readback after the second rising edge that follows, and not after the first.
- R11: After reset, the direction and output bits are all 0. Every pin is then an input with its pull-up off.
- R12: A direction write loads the data bus into the direction bits, and an output write loads it into the output bits. Both sets of bits are readable at the ports one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_we | input | 1 | Load direction bits from wdata |
| out_we | input | 1 | Load output bits from wdata |
| wdata | input | WIDTH | Write data |
| pull_off | input | 1 | Global pull-up disable |
| sleep | input | 1 | Power state, 1 = sleep |
| pu_ovr_en | input | WIDTH | Pull-up override enable |
| pu_ovr_val | input | WIDTH | Pull-up override value |
| oe_ovr_en | input | WIDTH | Output enable override enable |
| oe_ovr_val | input | WIDTH | Output enable override value |
| pv_ovr_en | input | WIDTH | Output value override enable |
| pv_ovr_val | input | WIDTH | Output value override value |
| tog_ovr | input | WIDTH | Toggle the stored output bit |
| ie_ovr_en | input | WIDTH | Input enable override enable |
| ie_ovr_val | input | WIDTH | Input enable override value |
| pad_in | input | WIDTH | Pad input level |
| pad_pu | output | WIDTH | Pull-up enable |
| pad_oe | output | WIDTH | Output driver enable |
| pad_out | output | WIDTH | Pad output value |
| pad_ie | output | WIDTH | Digital input enable |
| dir_q | output | WIDTH | Direction bits readback |
| out_q | output | WIDTH | Output bits readback |
| pin_q | output | WIDTH | Synchronized pin value |
| af_in | output | WIDTH | Unsynchronized gated input for peripherals |

## Verification
The bench builds the port with WIDTH = 4. This width is small enough that one vector can drive all pins to the same state, and wide enough that toggle and write patterns such as 0101 and 0011 show that each bit is handled on its own. The override table broadcasts one pin state to all four pins. The toggle, write-priority and synchronizer tests then use patterns that differ per pin, so a bit crossed over between pins would show up.

// File: rtl/gpio_override_port.sv
`timescale 1ns/1ps
module gpio_override_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_we,
  input  logic             out_we,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pull_off,
  input  logic             sleep,
  input  logic [WIDTH-1:0] pu_ovr_en,
  input  logic [WIDTH-1:0] pu_ovr_val,
  input  logic [WIDTH-1:0] oe_ovr_en,
  input  logic [WIDTH-1:0] oe_ovr_val,
  input  logic [WIDTH-1:0] pv_ovr_en,
  input  logic [WIDTH-1:0] pv_ovr_val,
  input  logic [WIDTH-1:0] tog_ovr,
  input  logic [WIDTH-1:0] ie_ovr_en,
  input  logic [WIDTH-1:0] ie_ovr_val,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_pu,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_ie,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] pin_q,
  output logic [WIDTH-1:0] af_in
);

  logic [WIDTH-1:0] dir_r, out_r, sync1, sync2;
  logic [WIDTH-1:0] pu_reg, ie_state, gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_r <= '0;
      out_r <= '0;
    end else begin
      if (dir_we) dir_r <= wdata;
      if (out_we) out_r <= wdata;
      else        out_r <= out_r ^ tog_ovr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= gated;
      sync2 <= sync1;
    end
  end

  assign pu_reg   = ~dir_r & out_r & {WIDTH{~pull_off}};
  assign pad_pu   = (pu_ovr_en & pu_ovr_val) | (~pu_ovr_en & pu_reg);
  assign pad_oe   = (oe_ovr_en & oe_ovr_val) | (~oe_ovr_en & dir_r);
  assign pad_out  = ((pad_oe & pv_ovr_en) & pv_ovr_val) | (~(pad_oe & pv_ovr_en) & out_r);
  assign ie_state = {WIDTH{~sleep}};
  assign pad_ie   = (ie_ovr_en & ie_ovr_val) | (~ie_ovr_en & ie_state);
  assign gated    = pad_in & pad_ie;

  assign af_in = gated;
  assign pin_q = sync2;
  assign dir_q = dir_r;
  assign out_q = out_r;

endmodule

// File: rtl/gpio_override_port_chk.sv
`timescale 1ns/1ps
module gpio_override_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_we,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] tog_ovr,
  input logic [WIDTH-1:0] pv_ovr_en,
  input logic [WIDTH-1:0] pv_ovr_val,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_ie,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] out_q,
  input logic [WIDTH-1:0] pin_q,
  input logic [WIDTH-1:0] af_in
);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R5
  toggle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_we |=> out_q == ($past(out_q) ^ $past(tog_ovr)));

  // R6
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |=> out_q == $past(wdata));

  // R10
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    since_rst >= 2'd2 |-> pin_q == $past(af_in, 2));

  // R8
  gate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (af_in & ~pad_ie) == '0);

  // R4
  value_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ pv_ovr_val) & pv_ovr_en & pad_oe) == '0);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (dir_q == '0 && out_q == '0));

endmodule

bind gpio_override_port gpio_override_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_we(out_we), .wdata(wdata), .tog_ovr(tog_ovr),
  .pv_ovr_en(pv_ovr_en), .pv_ovr_val(pv_ovr_val), .pad_oe(pad_oe),
  .pad_out(pad_out), .pad_ie(pad_ie), .dir_q(dir_q), .out_q(out_q),
  .pin_q(pin_q), .af_in(af_in)
);

// File: tb/sim_gpio_override_port.sv
`timescale 1ns/1ps
module sim_gpio_override_port;
  localparam int W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_we = 0, out_we = 0, pull_off = 0, sleep = 0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] pu_ovr_en = '0, pu_ovr_val = '0, oe_ovr_en = '0, oe_ovr_val = '0;
  logic [W-1:0] pv_ovr_en = '0, pv_ovr_val = '0, tog_ovr = '0;
  logic [W-1:0] ie_ovr_en = '0, ie_ovr_val = '0, pad_in = '0;
  logic [W-1:0] pad_pu, pad_oe, pad_out, pad_ie, dir_q, out_q, pin_q, af_in;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  gpio_override_port #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .dir_we(dir_we), .out_we(out_we), .wdata(wdata),
    .pull_off(pull_off), .sleep(sleep),
    .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val),
    .oe_ovr_en(oe_ovr_en), .oe_ovr_val(oe_ovr_val),
    .pv_ovr_en(pv_ovr_en), .pv_ovr_val(pv_ovr_val), .tog_ovr(tog_ovr),
    .ie_ovr_en(ie_ovr_en), .ie_ovr_val(ie_ovr_val), .pad_in(pad_in),
    .pad_pu(pad_pu), .pad_oe(pad_oe), .pad_out(pad_out), .pad_ie(pad_ie),
    .dir_q(dir_q), .out_q(out_q), .pin_q(pin_q), .af_in(af_in)
  );

  // {dir,out,pull_off, pu_en,pu_val, oe_en,oe_val, pv_en,pv_val, ie_en,ie_val,
  //  sleep, pad | exp pu,oe,out,ie,af}
  localparam logic [17:0] TBL [12] = '{
    18'b010_00_00_00_00_0_1_10111,  // R1 pull-up on
    18'b011_00_00_00_00_0_1_00111,  // R1 global disable
    18'b110_00_00_00_00_0_0_01110,  // R1 R3 output pin
    18'b000_00_00_00_00_0_1_00011,  // R1 out bit 0
    18'b100_11_00_00_00_0_0_11010,  // R2 forced on
    18'b010_10_00_00_00_0_1_00111,  // R2 forced off
    18'b000_00_11_11_00_0_0_01110,  // R3 R4 forced drive and value
    18'b110_00_10_10_00_0_1_00111,  // R3 R4 driver off ignores value override
    18'b100_00_00_11_00_0_0_01110,  // R4 value override
    18'b000_00_00_00_00_1_1_00000,  // R7 R8 sleep
    18'b000_00_00_00_11_1_1_00011,  // R7 override on in sleep
    18'b000_00_00_00_10_0_1_00000   // R7 R8 override off awake
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic to_dir, input logic [W-1:0] d);
    @(negedge clk);
    wdata = d;
    dir_we = to_dir;
    out_we = ~to_dir;
    @(negedge clk);
    dir_we = 0;
    out_we = 0;
  endtask

  function automatic logic [W-1:0] rep(input logic b);
    return {W{b}};
  endfunction

  initial begin
    #(5.0 * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 dir_q", dir_q, '0);
    check("R11 out_q", out_q, '0);
    check("R11 pad_pu", pad_pu, '0);
    check("R11 pad_oe", pad_oe, '0);

    wr(1'b1, 4'b1010);
    check("R12 dir_q", dir_q, 4'b1010);
    wr(1'b0, 4'b0101);
    check("R12 out_q", out_q, 4'b0101);

    for (int i = 0; i < 12; i++) begin
      logic [17:0] v;
      v = TBL[i];
      wr(1'b1, rep(v[17]));
      wr(1'b0, rep(v[16]));
      pull_off = v[15];
      pu_ovr_en = rep(v[14]); pu_ovr_val = rep(v[13]);
      oe_ovr_en = rep(v[12]); oe_ovr_val = rep(v[11]);
      pv_ovr_en = rep(v[10]); pv_ovr_val = rep(v[9]);
      ie_ovr_en = rep(v[8]);  ie_ovr_val = rep(v[7]);
      sleep = v[6];
      pad_in = rep(v[5]);
      #1;
      check($sformatf("R1-table vec%0d pu", i), pad_pu, rep(v[4]));
      check($sformatf("R3-table vec%0d oe", i), pad_oe, rep(v[3]));
      check($sformatf("R4-table vec%0d out", i), pad_out, rep(v[2]));
      check($sformatf("R7-table vec%0d ie", i), pad_ie, rep(v[1]));
      check($sformatf("R8-table vec%0d af", i), af_in, rep(v[0]));
    end

    pull_off = 0; sleep = 0;
    pu_ovr_en = '0; oe_ovr_en = '0; pv_ovr_en = '0; ie_ovr_en = '0;
    pad_in = '0;

    wr(1'b0, 4'b0011);
    tog_ovr = 4'b0101;
    @(negedge clk);
    tog_ovr = '0;
    check("R5 single toggle", out_q, 4'b0110);
    tog_ovr = 4'b1111;
    repeat (3) @(negedge clk);
    tog_ovr = '0;
    check("R5 held three cycles", out_q, 4'b1001);

    tog_ovr = 4'b1111;
    wdata = 4'b1100;
    out_we = 1;
    @(negedge clk);
    out_we = 0;
    tog_ovr = '0;
    check("R6 write beats toggle", out_q, 4'b1100);

    repeat (3) @(negedge clk);
    pad_in = 4'b1010;
    #0.5;
    check("R9 raw input immediate", af_in, 4'b1010);
    @(negedge clk);
    check("R10 pin after one edge", pin_q, 4'b0000);
    @(negedge clk);
    check("R10 pin after two edges", pin_q, 4'b1010);

    sleep = 1;
    pad_in = 4'b1111;
    #0.5;
    check("R8 raw input gated", af_in, 4'b0000);
    repeat (2) @(negedge clk);
    check("R8 pin gated", pin_q, 4'b0000);

    ie_ovr_en = 4'b0011;
    ie_ovr_val = 4'b0001;
    #0.5;
    check("R7 per-pin override", pad_ie, 4'b0001);
    repeat (2) @(negedge clk);
    check("R10 per-pin readback", pin_q, 4'b0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule